// File: doc/BRIEF.md
# Lock-Gated Processor Reset Sequencer

This block produces the reset for a processor that is clocked by an on-chip clock generator. Its output behaves like an open-drain pin: it either pulls the line low or lets go of it and leaves it at high impedance, where an external pull-up raises it. The line is held low for as long as the clock generator reports no lock, and for as long as the asynchronous active-low reset request is low. After both of those clear, the line stays low for a fixed number of system clock cycles and is then released. Because the line is only released while the clock is locked, it also serves as a lock indicator.

A low level on the reset request pulls the output low straight away, through combinational logic, without waiting for a clock edge. The rising edge of the request passes through a synchronizer before the release count can start. If lock is lost, or a new request arrives while the count runs, the count starts again from zero. A separate active-low power-on reset sets up the block's own state.

Top module: `lock_reset_seq`

## Requirements
- R1: While `porN` is low, `drvLow` is 1 and `released` is 0.
- R2: With `rstReqN` high, `drvLow` stays 1 for every cycle in which `lockIn` is low.
- R3: With `rstReqN` high and settled, `released` first reads 1 exactly `RELEASE_CYCLES` clock cycles after `lockIn` rises. Here that is counted in falling edges, starting at the falling edge where `lockIn` was set. The default is 1024.
- R4: A low level on `rstReqN` sets `drvLow` to 1 with no clock edge in between.
- R5: With lock held, `released` first reads 1 exactly `RELEASE_CYCLES + SYNC_STAGES` cycles after `rstReqN` rises. The synchronizer depth `SYNC_STAGES` defaults to 2.
- R6: If `rstReqN` is low when `porN` is released and stays low, `drvLow` stays 1 no matter what `lockIn` does.
- R7: A low pulse on `rstReqN` that falls entirely between two rising clock edges is captured. The release then takes the full R5 delay, measured from the pulse.
- R8: When `lockIn` falls, `drvLow` reads 1 after the next rising edge. This holds whether the block was counting or already released. When lock returns, the count restarts from zero.
- R9: A new low pulse on `rstReqN` during the count restarts it. Release then follows R5, measured from the new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| lockIn | input | 1 | Lock status from the clock generator, synchronous to clk |
| rstReqN | input | 1 | Reset request, active low, asynchronous |
| drvLow | output | 1 | 1 = pull the reset line low; 0 = high impedance |
| released | output | 1 | 1 = reset released and clock locked |

## Verification
The embedded properties check several behaviours on every cycle. The line is pulled low on the edge that follows any low sample of lock. The sequencer only reaches the released state right after the counter reports its final value. The counter only advances while the synchronized request and lock are both high, and a clear strobe always leaves it at zero. The exact release latencies can only be shown by the bench's scenarios: from lock rising, from the request rising, and after restarts caused by lock loss or a fresh request. The same goes for capture of a pulse narrower than a clock period and for a request held low through power-up.

// File: rtl/lock_reset_seq_pkg.sv
package lock_reset_seq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_REL   = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } cntCtl_t;

endpackage

// File: rtl/lock_reset_seq_dp.sv
module lock_reset_seq_dp
  import lock_reset_seq_pkg::*;
#(
  parameter int RELEASE_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic    clk,
  input  logic    arstN,
  input  logic    lockIn,
  input  cntCtl_t ctl,
  output logic    reqSync,
  output logic    cntLast
);
  localparam int CW = (RELEASE_CYCLES > 2) ? $clog2(RELEASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RELEASE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0]          cnt;

  // The synchronizer is cleared at once by a request; release ripples through it.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) syncQ[s] <= 1'b0;
        else if (s == 0) syncQ[s] <= 1'b1;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign reqSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)           cnt <= '0;
    else if (ctl.cntClear) cnt <= '0;
    else if (ctl.cntInc)   cnt <= cnt + 1'b1;
  end

  assign cntLast = (cnt == LAST);

  // R5: counting only advances once the request has passed the synchronizer and lock holds
  a_r5_inc_needs_sync: assert property (@(posedge clk) disable iff (!arstN)
    ctl.cntInc |-> (reqSync && lockIn));

  // R9: a clear strobe always leaves the counter at zero
  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!arstN)
    ctl.cntClear |=> (cnt == '0));

endmodule

// File: rtl/lock_reset_seq_ctl.sv
module lock_reset_seq_ctl
  import lock_reset_seq_pkg::*;
(
  input  logic    clk,
  input  logic    arstN,
  input  logic    lockIn,
  input  logic    reqSync,
  input  logic    cntLast,
  output cntCtl_t ctl,
  output logic    isReleased
);
  seqState_t state, stateNext;
  logic armed;

  assign armed = reqSync & lockIn;

  always_comb begin
    stateNext    = state;
    ctl.cntClear = 1'b0;
    ctl.cntInc   = 1'b0;
    unique case (state)
      ST_HOLD: begin
        if (armed) begin
          ctl.cntInc = 1'b1;
          stateNext  = ST_COUNT;
        end else begin
          ctl.cntClear = 1'b1;
        end
      end
      ST_COUNT: begin
        if (!armed) begin
          ctl.cntClear = 1'b1;
          stateNext    = ST_HOLD;
        end else if (cntLast) begin
          stateNext = ST_REL;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      ST_REL: begin
        if (!armed) begin
          ctl.cntClear = 1'b1;
          stateNext    = ST_HOLD;
        end
      end
      default: begin
        ctl.cntClear = 1'b1;
        stateNext    = ST_HOLD;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= ST_HOLD;
    else        state <= stateNext;
  end

  assign isReleased = (state == ST_REL);

  // R8: a released sequencer drops back to hold on the edge after lock is lost
  a_r8_lock_loss_rearms: assert property (@(posedge clk) disable iff (!arstN)
    (isReleased && !lockIn) |=> !isReleased);

  // R3: release is only entered after the counter reached its final value
  a_r3_release_after_last: assert property (@(posedge clk) disable iff (!arstN)
    $rose(isReleased) |-> $past(cntLast));

endmodule

// File: rtl/lock_reset_seq.sv
module lock_reset_seq
  import lock_reset_seq_pkg::*;
#(
  parameter int RELEASE_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic lockIn,
  input  logic rstReqN,
  output logic drvLow,
  output logic released
);
  logic    arstN;
  logic    reqSync;
  logic    cntLast;
  logic    isReleased;
  cntCtl_t ctl;

  assign arstN = porN & rstReqN;

  lock_reset_seq_dp #(
    .RELEASE_CYCLES(RELEASE_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .arstN  (arstN),
    .lockIn (lockIn),
    .ctl    (ctl),
    .reqSync(reqSync),
    .cntLast(cntLast)
  );

  lock_reset_seq_ctl u_ctl (
    .clk       (clk),
    .arstN     (arstN),
    .lockIn    (lockIn),
    .reqSync   (reqSync),
    .cntLast   (cntLast),
    .ctl       (ctl),
    .isReleased(isReleased)
  );

  // The request path bypasses the clock so assertion is immediate.
  assign drvLow   = ~rstReqN | ~isReleased;
  assign released = ~drvLow;

  // R2: any cycle without lock leaves the line pulled low after the edge
  a_r2_low_without_lock: assert property (@(posedge clk) disable iff (!arstN)
    !lockIn |=> drvLow);

endmodule

// File: tb/tb_lock_reset_seq.sv
`timescale 1ns/1ps
module tb_lock_reset_seq;
  localparam int N  = 1024;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic porN, lockIn, rstReqN;
  logic drvLow, released;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lock_reset_seq #(.RELEASE_CYCLES(N), .SYNC_STAGES(SS)) dut (
    .clk(clk), .porN(porN), .lockIn(lockIn), .rstReqN(rstReqN),
    .drvLow(drvLow), .released(released)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts falling edges from now until released is seen high.
  task automatic measure(input string req, input int exp);
    int k = 0;
    for (int i = 1; i <= exp + 50; i++) begin
      @(negedge clk);
      if (released) begin k = i; break; end
    end
    check(req, k, exp);
  endtask

  localparam int NV = 4;
  // each row: cycles without lock before lock rises, expected release latency
  localparam int VEC_DELAY[NV] = '{0, 3, 17, 90};
  localparam int VEC_EXP[NV]   = '{N, N, N, N};

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    porN = 1'b0; lockIn = 1'b0; rstReqN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 drvLow", drvLow, 1);
    check("R1 released", released, 0);
    porN = 1'b1;
    repeat (5) @(negedge clk);

    // Table: lock arrives after various delays
    for (int v = 0; v < NV; v++) begin
      lockIn = 1'b0;
      @(negedge clk);
      check("R8 low after lock drop", drvLow, 1);
      for (int d = 0; d < VEC_DELAY[v]; d++) begin
        @(negedge clk);
        if (!drvLow) check("R2 held low without lock", drvLow, 1);
      end
      check("R2 low before lock", drvLow, 1);
      lockIn = 1'b1;
      measure("R3 release after lock", VEC_EXP[v]);
    end

    // R4 and R5: request pulse while locked
    rstReqN = 1'b0;
    #1;
    check("R4 immediate drive low", drvLow, 1);
    repeat (4) @(negedge clk);
    rstReqN = 1'b1;
    measure("R5 release after request", N + SS);

    // R7: narrow pulse between rising edges
    @(negedge clk);
    #2 rstReqN = 1'b0;
    #1 check("R7 narrow pulse drives low", drvLow, 1);
    #1 rstReqN = 1'b1;
    begin
      int k = 0;
      for (int i = 1; i <= N + SS + 50; i++) begin
        @(negedge clk);
        if (released) begin k = i; break; end
      end
      check("R7 narrow pulse full delay", k, N + SS);
    end

    // R8: lock lost mid-count restarts
    lockIn = 1'b0;
    @(negedge clk);
    lockIn = 1'b1;
    repeat (500) @(negedge clk);
    check("R8 still low mid count", drvLow, 1);
    lockIn = 1'b0;
    @(negedge clk);
    check("R8 low after mid-count loss", drvLow, 1);
    repeat (2) @(negedge clk);
    lockIn = 1'b1;
    measure("R8 restart from zero", N);

    // R9: new request during count restarts
    rstReqN = 1'b0;
    @(negedge clk);
    rstReqN = 1'b1;
    repeat (600) @(negedge clk);
    rstReqN = 1'b0;
    @(negedge clk);
    rstReqN = 1'b1;
    measure("R9 restart on new request", N + SS);

    // R6: request held low through power-up
    porN = 1'b0; rstReqN = 1'b0; lockIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset again", drvLow, 1);
    porN = 1'b1;
    begin
      int bad = 0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (i == 1500) lockIn = 1'b0;
        if (i == 1600) lockIn = 1'b1;
        if (!drvLow) bad++;
      end
      check("R6 held low with request low", bad, 0);
    end
    rstReqN = 1'b1;
    measure("R5 release after held request", N + SS);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule